// File: doc/BRIEF.md
# Two-Step Converter Digital Back-End

This block sits behind the analog comparators of a two-step 8-bit converter. A coarse comparator group resolves the upper nibble. Two fine comparator groups, bank A and bank B, resolve the lower nibble and take turns on successive samples. Each group hands the block a 15-bit thermometer word. The block turns each word into a 4-bit code and tells the comparators which fine bank samples next. It also gives each bank a phase strobe. The block then pairs every coarse nibble with the fine nibble from the same sample and drives the merged byte onto an 8-bit bus. That bus can be released to high impedance.

The comparators take their samples on the falling clock edge. All logic in this block runs on the rising edge. The coarse word for a sample is captured one rising edge after the sample is taken. The fine word of the bank that took the sample is captured on the rising edge after that. The merged byte is registered on the third rising edge. This gives a latency of two and a half clock cycles, and after the pipeline has filled, a new byte appears on every rising edge.

A small sequencer controls the bank rotation. It has three states. SEQ_IDLE is the reset state: no bank samples and both strobes show idle. SEQ_A means bank A samples on the coming falling edge while bank B converts. SEQ_B is the mirror of SEQ_A. The transitions are:
- idle_to_a: the first rising edge with reset low moves SEQ_IDLE to SEQ_A.
- a_to_b: SEQ_A moves to SEQ_B on every rising edge.
- b_to_a: SEQ_B moves to SEQ_A on every rising edge.
- reset: reset forces SEQ_IDLE from any state.

Top module: `adc2s_backend`

## Requirements
- R1: A thermometer word encodes to the number of consecutive 1 bits counted upward from bit 0. Any 1 bit above the first 0 is a bubble and is ignored. So all zeros gives 0, all ones gives 15, and a word with bit 0 clear gives 0.
- R2: The output byte is straight binary. Bits 7:4 carry the coarse code and bits 3:0 carry the fine code, so the bottom reference gives 0x00 and the top reference gives 0xFF.
- R3: Number the rising edges after reset release from 0. A sample taken on the falling edge after rising edge k has its coarse word read at edge k+1 and its fine word read at edge k+2. Its byte is on dout after edge k+3, and one new byte follows on each later edge.
- R4: bank_sel is 0 (bank A) for the falling edge after rising edge 0. It then toggles on every rising edge.
- R5: The fine code is taken only from the bank that took that sample. The other bank's word is ignored, whatever value it holds.
- R6: phase_a and phase_b use the codes 0 = idle, 1 = sample, 2 = convert. Convert covers hold followed by compare. Outside reset, the bank chosen by bank_sel shows 1 and the other bank shows 2. While the sequencer is idle, both show 0.
- R7: Reset is synchronous and active high. During reset, dout is 0x00 and bank_sel is 0. After release, the first three bytes are 0x00, until the first real sample arrives.
- R8: While oe_n is 1, all eight dout lines are high impedance. While oe_n is 0, dout carries the byte. The pipeline keeps running while the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; comparators sample on its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| coarse_therm | input | 15 | Coarse comparator thermometer word |
| fine_a_therm | input | 15 | Fine bank A thermometer word |
| fine_b_therm | input | 15 | Fine bank B thermometer word |
| oe_n | input | 1 | Output enable, active low |
| bank_sel | output | 1 | Fine bank that samples on the coming falling edge (0 = A, 1 = B) |
| phase_a | output | 2 | Bank A phase strobe (0 idle, 1 sample, 2 convert) |
| phase_b | output | 2 | Bank B phase strobe (0 idle, 1 sample, 2 convert) |
| dout | output | 8 | Converted byte, high impedance while oe_n is 1 |

## Verification
The directed codes come first. They are 0x00, 0xFF and 0x80/0x7F, which exercise the ends of the range and the step where the nibble boundary carries. Nibble-skewed values such as 0x0F/0xF0 follow; they catch coarse and fine swapping places. Random codes follow, and in some of them a bubble bit is placed above the run of ones, or a hole is cut below the top of the run. These separate counting from the bottom from plain popcount or top-bit detection. The bank that is not converting always has random data on its word, so a wrong bank choice or a one-cycle slip in the pairing shows up as a byte mismatch. A window with the bus released is placed over nonzero bytes. A second reset in the middle of the stream confirms that the pipeline refills with zeros.

// File: rtl/adc2s_pkg.sv
package adc2s_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_A    = 2'd1,
        SEQ_B    = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SAMPLE  = 2'd1,
        PH_CONVERT = 2'd2
    } bank_phase_e;

    localparam int unsigned NUM_GROUPS = 3;

endpackage

// File: rtl/adc2s_therm_enc.sv
module adc2s_therm_enc #(
    parameter int unsigned NIB_W = 4
) (
    input  logic [(2**NIB_W)-2:0] therm,
    output logic [NIB_W-1:0]      code
);
    localparam int unsigned THERM_W = (2**NIB_W) - 1;

    logic             run;
    logic [NIB_W-1:0] cnt;

    // Count the unbroken run of ones from bit 0; anything above the first
    // zero is a bubble and does not contribute.
    always_comb begin
        run = 1'b1;
        cnt = '0;
        for (int i = 0; i < THERM_W; i++) begin
            if (run && therm[i]) begin
                cnt = cnt + 1'b1;
            end else begin
                run = 1'b0;
            end
        end
        code = cnt;
    end

endmodule

// File: rtl/adc2s_seq.sv
module adc2s_seq
    import adc2s_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic        bank_sel,
    output logic        active,
    output bank_phase_e ph_a,
    output bank_phase_e ph_b
);
    seq_state_e st, st_nxt;

    // next-state
    always_comb begin
        unique case (st)
            SEQ_IDLE: st_nxt = SEQ_A;
            SEQ_A:    st_nxt = SEQ_B;
            SEQ_B:    st_nxt = SEQ_A;
            default:  st_nxt = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st <= SEQ_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // outputs
    always_comb begin
        bank_sel = 1'b0;
        active   = 1'b0;
        ph_a     = PH_IDLE;
        ph_b     = PH_IDLE;
        unique case (st)
            SEQ_IDLE: begin
                bank_sel = 1'b0;
            end
            SEQ_A: begin
                active = 1'b1;
                ph_a   = PH_SAMPLE;
                ph_b   = PH_CONVERT;
            end
            SEQ_B: begin
                active   = 1'b1;
                bank_sel = 1'b1;
                ph_a     = PH_CONVERT;
                ph_b     = PH_SAMPLE;
            end
            default: begin
                active = 1'b0;
            end
        endcase
    end

    assert_a_then_b_R4: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_A) |=> (st == SEQ_B));

    assert_b_then_a_R4: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_B) |=> (st == SEQ_A));

    assert_idle_leaves_R4: assert property (@(posedge clk) disable iff (rst)
        (st == SEQ_IDLE) |=> (st == SEQ_A));

endmodule

// File: rtl/adc2s_align.sv
module adc2s_align #(
    parameter int unsigned NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic               bank_sel,
    input  logic [NIB_W-1:0]   coarse_code,
    input  logic [NIB_W-1:0]   fine_a_code,
    input  logic [NIB_W-1:0]   fine_b_code,
    output logic [2*NIB_W-1:0] out_word
);
    localparam int unsigned OUT_W = 2 * NIB_W;

    logic [NIB_W-1:0] coarse_q1, coarse_q2, fine_q;
    logic             bank_q1, vld_q1, vld_q2;
    logic [OUT_W-1:0] out_q;

    // edge k+1: coarse final, remember which bank took the sample
    always_ff @(posedge clk) begin
        if (rst) begin
            coarse_q1 <= '0;
            bank_q1   <= 1'b0;
            vld_q1    <= 1'b0;
        end else begin
            coarse_q1 <= coarse_code;
            bank_q1   <= bank_sel;
            vld_q1    <= active;
        end
    end

    // edge k+2: fine final from the bank that sampled
    always_ff @(posedge clk) begin
        if (rst) begin
            fine_q    <= '0;
            coarse_q2 <= '0;
            vld_q2    <= 1'b0;
        end else begin
            fine_q    <= bank_q1 ? fine_b_code : fine_a_code;
            coarse_q2 <= coarse_q1;
            vld_q2    <= vld_q1;
        end
    end

    // edge k+3: merged word
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (vld_q2) begin
            out_q <= {coarse_q2, fine_q};
        end else begin
            out_q <= '0;
        end
    end

    assign out_word = out_q;

    assert_fill_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !vld_q2 |=> (out_q == '0));

    assert_coarse_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        vld_q2 |=> (out_q[OUT_W-1:NIB_W] == $past(coarse_q1, 2)));

endmodule

// File: rtl/adc2s_backend.sv
module adc2s_backend
    import adc2s_pkg::*;
#(
    parameter int unsigned NIB_W   = 4,
    parameter int unsigned THERM_W = (2**NIB_W) - 1,
    parameter int unsigned OUT_W   = 2 * NIB_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [THERM_W-1:0] coarse_therm,
    input  logic [THERM_W-1:0] fine_a_therm,
    input  logic [THERM_W-1:0] fine_b_therm,
    input  logic               oe_n,
    output logic               bank_sel,
    output logic [1:0]         phase_a,
    output logic [1:0]         phase_b,
    output logic [OUT_W-1:0]   dout
);
    logic [THERM_W-1:0] therm_in [NUM_GROUPS];
    logic [NIB_W-1:0]   code_v   [NUM_GROUPS];

    assign therm_in[0] = coarse_therm;
    assign therm_in[1] = fine_a_therm;
    assign therm_in[2] = fine_b_therm;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_enc
        adc2s_therm_enc #(.NIB_W(NIB_W)) u_enc (
            .therm (therm_in[g]),
            .code  (code_v[g])
        );
    end

    logic        active;
    bank_phase_e ph_a, ph_b;

    adc2s_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .bank_sel (bank_sel),
        .active   (active),
        .ph_a     (ph_a),
        .ph_b     (ph_b)
    );

    assign phase_a = ph_a;
    assign phase_b = ph_b;

    logic [OUT_W-1:0] out_word;

    adc2s_align #(.NIB_W(NIB_W)) u_align (
        .clk         (clk),
        .rst         (rst),
        .active      (active),
        .bank_sel    (bank_sel),
        .coarse_code (code_v[0]),
        .fine_a_code (code_v[1]),
        .fine_b_code (code_v[2]),
        .out_word    (out_word)
    );

    assign dout = oe_n ? {OUT_W{1'bz}} : out_word;

    assert_sampler_follows_sel_R6: assert property (@(posedge clk) disable iff (rst)
        active |-> (bank_sel ? (ph_b == PH_SAMPLE && ph_a == PH_CONVERT)
                             : (ph_a == PH_SAMPLE && ph_b == PH_CONVERT)));

endmodule

// File: tb/tb_adc2s_backend.sv
module tb_adc2s_backend;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        oe_n = 1'b0;
    logic [14:0] coarse_w = '0, fa_w = '0, fb_w = '0;
    wire  [7:0]  dout;
    logic        bank_sel;
    logic [1:0]  phase_a, phase_b;

    always #4 clk = ~clk;

    adc2s_backend dut (
        .clk(clk), .rst(rst), .coarse_therm(coarse_w), .fine_a_therm(fa_w),
        .fine_b_therm(fb_w), .oe_n(oe_n), .bank_sel(bank_sel),
        .phase_a(phase_a), .phase_b(phase_b), .dout(dout)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] exp_word [0:255];
    logic [3:0] exp_coarse [0:255];
    logic [7:0] samp [0:255];
    bit         bub [0:255];

    task automatic check(string req, bit ok, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] f_enc(logic [14:0] w);
        int n = 0;
        while (n < 15 && w[n]) n++;
        return 4'(n);
    endfunction

    function automatic logic [14:0] f_therm(int n, int kind);
        logic [15:0] t = (16'd1 << n) - 16'd1;
        if (kind == 1 && n <= 12) t[n+1] = 1'b1;      // bubble above the run
        if (kind == 2 && n >= 2)  t[n-2] = 1'b0;      // hole inside the run
        return t[14:0];
    endfunction

    function automatic logic [7:0] f_directed(int j);
        case (j)
            0: return 8'h00;  1: return 8'hFF;  2: return 8'h0F;  3: return 8'hF0;
            4: return 8'h80;  5: return 8'h7F;  6: return 8'h01;  7: return 8'hFE;
            8: return 8'h10;  9: return 8'hEF; 10: return 8'h55; 11: return 8'hAA;
            default: return 8'h00;
        endcase
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic check_reset_state();
        @(negedge clk);
        check("R7", dout === 8'h00, 16'(dout), 16'h00);
        check("R7", bank_sel === 1'b0, 16'(bank_sel), 16'h0);
        check("R6", phase_a === 2'd0 && phase_b === 2'd0, {phase_a, phase_b}, 16'h0);
    endtask

    task automatic run_stream(int n_samp);
        bit oe_cur = 0;
        for (int j = 0; j < n_samp; j++) begin
            @(negedge clk);
            // ---- checks for this cycle
            check("R4", bank_sel === j[0], 16'(bank_sel), 16'(j[0]));
            check("R6", phase_a === (j[0] ? 2'd2 : 2'd1) && phase_b === (j[0] ? 2'd1 : 2'd2),
                  {phase_a, phase_b}, j[0] ? 16'h21 : 16'h12);
            if (oe_cur) begin
                // R8: released bus; the word underneath is nonzero by construction
                check("R8", (dout === 8'hzz) || (dout === 8'h00), 16'(dout), 16'h00zz);
            end else if (j >= 3) begin
                check(bub[j-3] ? "R1" : (j < 15 ? "R2" : (j[0] ? "R5" : "R3")),
                      dout === exp_word[j-3], 16'(dout), 16'(exp_word[j-3]));
            end else begin
                check("R7", dout === 8'h00, 16'(dout), 16'h00);
            end
            // ---- drive the sample taken on this falling edge
            begin
                logic [7:0]  s;
                logic [14:0] cw, fw;
                int kc, kf;
                bit quiet = (j >= 30 && j <= 50);
                s  = (j < 12) ? f_directed(j) : 8'($urandom);
                kc = (j < 12 || quiet) ? 0 : int'($urandom % 4);
                kf = (j < 12 || quiet) ? 0 : int'($urandom % 4);
                if (quiet) s = s | 8'h11;
                samp[j] = s;
                cw = f_therm(int'(s[7:4]), (kc == 3) ? 0 : kc);
                exp_coarse[j] = f_enc(cw);
                bub[j] = (kc == 1 || kc == 2);
                coarse_w = cw;
                // the bank sampling now holds a don't-care word (R5)
                if (j[0]) fb_w = 15'($urandom); else fa_w = 15'($urandom);
                if (j >= 1) begin
                    fw = f_therm(int'(samp[j-1][3:0]), (kf == 3) ? 0 : kf);
                    exp_word[j-1] = {exp_coarse[j-1], f_enc(fw)};
                    if (kf == 1 || kf == 2) bub[j-1] = 1'b1;
                    if (j[0]) fa_w = fw; else fb_w = fw;
                end
                oe_cur = (j >= 40 && j < 48);
                oe_n   = oe_cur;
            end
        end
    endtask

    initial begin
        repeat (3) check_reset_state();
        rst = 1'b0;
        run_stream(220);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) check_reset_state();
        rst = 1'b0;
        run_stream(60);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_bad++;
            $display("FAIL R3 watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1179));
    end

endmodule